// File: doc/BRIEF.md
# Zigzag Scan Address Sequencer

This block walks an N by N block (N = 8 by default) in the zigzag order used by block transform coders, producing one column/row coordinate per cycle. It holds no table of positions. A short program of moves drives a coordinate counter. Each move is either a single step by a fixed vector (east, south, west, north) or a diagonal run. A diagonal run repeats its step until it reaches the top row or the left column, with a limit of N steps. The program first covers the upper-left triangle up to the top-right corner. It then crosses the main anti-diagonal. The last part replays the first program backwards, and its coordinates are reflected through the block centre.

A one-cycle start pulse launches a scan. The block then presents one coordinate per cycle on which it is not stalled. With each coordinate it gives the row-major linear index and a valid flag, and it raises a last flag alongside the final coordinate. Coordinates are 1-based: x is the column and y is the row.

Top module: `zz_scan_seq`

## Requirements
- R1: With the sequencer idle and stall low, a start pulse makes the next cycle show valid high, x = 1, y = 1 and index 0.
- R2: A scan presents exactly N*N coordinates with no repeats. They run along the anti-diagonals of constant x+y, taken in increasing order of that sum. Along a diagonal whose sum is odd, x falls from one coordinate to the next. Along a diagonal whose sum is even, x rises.
- R3: Coordinate number N*(N-1)/2 (counting from 0, so 28 for N = 8) is (N,1). The following N-1 coordinates walk the anti-diagonal x+y = N+1 down to (1,N).
- R4: For each coordinate number k after the anti-diagonal (k from N*(N+1)/2 to N*N-1), coordinate k equals (N+1-x, N+1-y) of coordinate N*N-1-k.
- R5: The linear index output equals (y-1)*N + (x-1) whenever valid is high.
- R6: Last is high only together with the N*N-th coordinate, which is (N,N). If stall is low in that cycle, valid is low in the cycle after.
- R7: While stall is high, valid, x, y, index and last keep their values. The scan resumes where it stopped with no coordinate lost or doubled.
- R8: A start pulse while valid is high, including the cycle that shows last, has no effect on the scan or on the idle state that follows it.
- R9: Two consecutive coordinates of a scan differ by at most one in x and at most one in y, and they are never equal.
- R10: Synchronous reset high at a clock edge makes valid low after that edge. The block then stays idle until a new start pulse.
- R11: After reset, valid and last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, accepted only when idle and not stalled |
| stall_i | input | 1 | Freezes the sequencer and its outputs |
| valid_o | output | 1 | A coordinate is presented |
| x_o | output | $clog2(N+2) | Column, 1-based |
| y_o | output | $clog2(N+2) | Row, 1-based |
| idx_o | output | $clog2(N*N) | Row-major linear index (y-1)*N + (x-1) |
| last_o | output | 1 | Final coordinate of the scan |

## Verification
An error in the program counter, the diagonal step count or the mirror flag shows on the very next valid cycle as a coordinate that is not on the zigzag path. It often also breaks the one-step adjacency between neighbours. A wrong decision on when the program ends shows as last rising on the wrong coordinate, or as valid staying high past the corner. A faulty reflection step shows as a second half that no longer matches the first half read backwards and reflected. The bench compares the full path, the indices and the reflection symmetry in normal runs, stalled runs and runs with an extra start pulse.

// File: rtl/zz_scan_pkg.sv
package zz_scan_pkg;

    // Primitive moves of the coordinate counter
    typedef enum logic [2:0] {
        MV_EAST,
        MV_SOUTH,
        MV_WEST,
        MV_NORTH,
        MV_NE_TO_TOP,   // repeat (+1,-1) until row 1
        MV_SW_TO_LEFT   // repeat (-1,+1) until column 1
    } move_e;

endpackage

// File: rtl/zz_move_prog.sv
module zz_move_prog
    import zz_scan_pkg::*;
#(
    parameter int N = 8,
    localparam int REP     = (N - 2) / 2,
    localparam int PC_FLIP = 1 + 4 * REP,
    localparam int PC_END  = PC_FLIP + 1 + 4 * REP,
    localparam int PCW     = $clog2(PC_END + 1)
) (
    input  logic [PCW-1:0] pc_i,
    output move_e          mv_o,
    output logic           flip_o,
    output logic           end_o
);

    logic [1:0] fwd_slot;
    logic [1:0] rev_slot;

    always_comb begin
        fwd_slot = 2'(pc_i - PCW'(1));
        rev_slot = 2'(pc_i - PCW'(PC_FLIP + 2));
        flip_o   = (pc_i == PCW'(PC_FLIP));
        end_o    = (pc_i == PCW'(PC_END));

        if (pc_i == '0) begin
            mv_o = MV_EAST;
        end else if (pc_i < PCW'(PC_FLIP)) begin
            // forward group: down-left run, south, up-right run, east
            case (fwd_slot)
                2'd0:    mv_o = MV_SW_TO_LEFT;
                2'd1:    mv_o = MV_SOUTH;
                2'd2:    mv_o = MV_NE_TO_TOP;
                default: mv_o = MV_EAST;
            endcase
        end else if (pc_i == PCW'(PC_FLIP)) begin
            mv_o = MV_SW_TO_LEFT;          // main anti-diagonal
        end else if (pc_i == PCW'(PC_FLIP + 1)) begin
            mv_o = MV_WEST;                // undo the last east
        end else begin
            // forward groups replayed backwards, each move inverted
            case (rev_slot)
                2'd0:    mv_o = MV_SW_TO_LEFT;
                2'd1:    mv_o = MV_NORTH;
                2'd2:    mv_o = MV_NE_TO_TOP;
                default: mv_o = MV_WEST;
            endcase
        end
    end

endmodule

// File: rtl/zz_step_unit.sv
module zz_step_unit
    import zz_scan_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = $clog2(N + 2),
    localparam int KW = (N > 2) ? $clog2(N) : 1
) (
    input  move_e         mv_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic [KW-1:0] cnt_i,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          fin_o
);

    logic cap_hit;

    always_comb begin
        cap_hit = (cnt_i == KW'(N - 1));
        x_o     = x_i;
        y_o     = y_i;
        fin_o   = 1'b1;
        case (mv_i)
            MV_EAST:  x_o = x_i + CW'(1);
            MV_SOUTH: y_o = y_i + CW'(1);
            MV_WEST:  x_o = x_i - CW'(1);
            MV_NORTH: y_o = y_i - CW'(1);
            MV_NE_TO_TOP: begin
                x_o   = x_i + CW'(1);
                y_o   = y_i - CW'(1);
                fin_o = (y_o == CW'(1)) || cap_hit;
            end
            MV_SW_TO_LEFT: begin
                x_o   = x_i - CW'(1);
                y_o   = y_i + CW'(1);
                fin_o = (x_o == CW'(1)) || cap_hit;
            end
            default: fin_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/zz_scan_seq.sv
module zz_scan_seq
    import zz_scan_pkg::*;
#(
    parameter int N = 8,
    localparam int CW = $clog2(N + 2),
    localparam int IW = $clog2(N * N)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic          stall_i,
    output logic          valid_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);

    localparam int REP     = (N - 2) / 2;
    localparam int PC_FLIP = 1 + 4 * REP;
    localparam int PC_END  = PC_FLIP + 1 + 4 * REP;
    localparam int PCW     = $clog2(PC_END + 1);
    localparam int KW      = (N > 2) ? $clog2(N) : 1;

    typedef struct packed {
        logic           active;
        logic           last;
        logic           mirror;
        logic [PCW-1:0] pc;
        logic [KW-1:0]  cnt;
        logic [CW-1:0]  ix;
        logic [CW-1:0]  iy;
    } seq_t;

    seq_t          st_d, st_q;
    move_e         mv;
    logic          at_flip, at_end, step_fin;
    logic [CW-1:0] nx, ny;

    zz_move_prog #(.N(N)) u_prog (
        .pc_i   (st_q.pc),
        .mv_o   (mv),
        .flip_o (at_flip),
        .end_o  (at_end)
    );

    zz_step_unit #(.N(N)) u_step (
        .mv_i  (mv),
        .x_i   (st_q.ix),
        .y_i   (st_q.iy),
        .cnt_i (st_q.cnt),
        .x_o   (nx),
        .y_o   (ny),
        .fin_o (step_fin)
    );

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            if (!st_q.active) begin
                if (start_i) begin
                    st_d        = '0;
                    st_d.active = 1'b1;
                    st_d.ix     = CW'(1);
                    st_d.iy     = CW'(1);
                end
            end else if (st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.ix = nx;
                st_d.iy = ny;
                if (step_fin) begin
                    st_d.cnt = '0;
                    st_d.pc  = st_q.pc + PCW'(1);
                    if (at_flip) begin
                        // continue in the reflected frame
                        st_d.ix     = CW'(N + 1) - nx;
                        st_d.iy     = CW'(N + 1) - ny;
                        st_d.mirror = 1'b1;
                    end
                    if (at_end) begin
                        st_d.last = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + KW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = st_q.last;
    assign x_o     = st_q.mirror ? CW'(N + 1) - st_q.ix : st_q.ix;
    assign y_o     = st_q.mirror ? CW'(N + 1) - st_q.iy : st_q.iy;
    assign idx_o   = IW'((int'(y_o) - 1) * N + int'(x_o) - 1);

    // R1: a start from idle opens at the top-left corner
    assert_origin_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_o && start_i && !stall_i) |=> (valid_o && x_o == CW'(1) && y_o == CW'(1)));

    // R9: neighbours on the path are one king move apart
    assert_adjacent_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !last_o && !stall_i) |=>
            (valid_o
             && (x_o == $past(x_o) || x_o == $past(x_o) + CW'(1) || x_o + CW'(1) == $past(x_o))
             && (y_o == $past(y_o) || y_o == $past(y_o) + CW'(1) || y_o + CW'(1) == $past(y_o))
             && !(x_o == $past(x_o) && y_o == $past(y_o))));

    // R7: stall freezes everything visible
    assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && stall_i) |=> (valid_o && $stable(x_o) && $stable(y_o) && $stable(last_o)));

    // R6: last sits on the far corner and the scan then ends
    assert_last_corner_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        last_o |-> (valid_o && x_o == CW'(N) && y_o == CW'(N)));
    assert_last_exit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (last_o && !stall_i) |=> !valid_o);

    // R8: a start while busy does not restart the path
    assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !last_o && !stall_i && start_i) |=>
            (valid_o && !(x_o == CW'(1) && y_o == CW'(1))));

endmodule

// File: tb/test_zz_scan_seq.sv
`timescale 1ns/1ps
module test_zz_scan_seq;

    localparam int N  = 8;
    localparam int CW = $clog2(N + 2);
    localparam int IW = $clog2(N * N);
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic          start_i = 1'b0;
    logic          stall_i = 1'b0;
    logic          valid_o;
    logic [CW-1:0] x_o, y_o;
    logic [IW-1:0] idx_o;
    logic          last_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_x [NN];
    int exp_y [NN];
    int got_x [NN];
    int got_y [NN];

    always #10 clk = ~clk;

    zz_scan_seq #(.N(N)) i_zz_scan_seq (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .start_i (start_i),
        .stall_i (stall_i),
        .valid_o (valid_o),
        .x_o     (x_o),
        .y_o     (y_o),
        .idx_o   (idx_o),
        .last_o  (last_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // zigzag path built from diagonal ordering, independent of the move program
    task automatic build_expected();
        int n = 0;
        for (int s = 2; s <= 2 * N; s++) begin
            for (int t = 0; t < N; t++) begin
                int top = (s - 1 < N) ? s - 1 : N;
                int a = top - t;
                int b = s - a;
                if (a >= 1 && b >= 1 && b <= N) begin
                    if (s % 2 == 1) begin
                        exp_x[n] = a; exp_y[n] = b;   // odd sum: x falls
                    end else begin
                        exp_y[n] = a; exp_x[n] = b;   // even sum: x rises
                    end
                    n++;
                end
            end
        end
    endtask

    task automatic chk_coord(input int k, input string req);
        int want_last = (k == NN - 1) ? 1 : 0;
        chk(valid_o == 1'b1, req, $sformatf("valid at %0d", k), int'(valid_o), 1);
        chk(int'(x_o) == exp_x[k] && int'(y_o) == exp_y[k], req,
            $sformatf("xy*16 at %0d", k), int'(x_o) * 16 + int'(y_o), exp_x[k] * 16 + exp_y[k]);
        chk(int'(idx_o) == (exp_y[k] - 1) * N + exp_x[k] - 1, "R5",
            $sformatf("index at %0d", k), int'(idx_o), (exp_y[k] - 1) * N + exp_x[k] - 1);
        chk(int'(last_o) == want_last, "R6", $sformatf("last at %0d", k), int'(last_o), want_last);
    endtask

    // one scan; optional stall at coordinate stall_k, optional extra start at busy_k
    task automatic run_scan(input int stall_k, input int busy_k);
        logic [NN-1:0] seen = '0;
        int dup = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk_coord(0, "R1");
        for (int k = 0; k < NN; k++) begin
            if (k > 0) chk_coord(k, "R2");
            got_x[k] = int'(x_o);
            got_y[k] = int'(y_o);
            if (k > 0) begin
                int dx = got_x[k] - got_x[k-1];
                int dy = got_y[k] - got_y[k-1];
                chk(dx >= -1 && dx <= 1 && dy >= -1 && dy <= 1 && (dx != 0 || dy != 0),
                    "R9", $sformatf("step dx*4+dy at %0d", k), dx * 4 + dy, 0);
            end
            if (idx_o < IW'(NN) && seen[idx_o]) dup++;
            seen[idx_o] = 1'b1;
            if (k == stall_k) begin
                stall_i = 1'b1;
                @(negedge clk);
                chk_coord(k, "R7");
                @(negedge clk);
                chk_coord(k, "R7");
                stall_i = 1'b0;
            end
            if (k == busy_k) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(valid_o == 1'b0, "R6", "valid after last", int'(valid_o), 0);
        chk(dup == 0 && seen == '1, "R2", "repeated coordinates", dup, 0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R8", "idle after scan", int'(valid_o), 0);
        for (int k = N * (N - 1) / 2; k < N * (N + 1) / 2; k++) begin
            int i = k - N * (N - 1) / 2;
            chk(got_x[k] == N - i && got_y[k] == 1 + i, "R3",
                $sformatf("anti-diagonal xy*16 at %0d", k), got_x[k] * 16 + got_y[k],
                (N - i) * 16 + 1 + i);
        end
        for (int k = N * (N + 1) / 2; k < NN; k++) begin
            int m = NN - 1 - k;
            chk(got_x[k] == N + 1 - got_x[m] && got_y[k] == N + 1 - got_y[m], "R4",
                $sformatf("reflection xy*16 at %0d", k), got_x[k] * 16 + got_y[k],
                (N + 1 - got_x[m]) * 16 + N + 1 - got_y[m]);
        end
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        chk(valid_o == 1'b0, "R11", "valid after reset", int'(valid_o), 0);
        chk(last_o == 1'b0, "R11", "last after reset", int'(last_o), 0);
        @(negedge clk);
        chk(valid_o == 1'b0, "R11", "valid idle", int'(valid_o), 0);
    endtask

    task automatic t_plain_scan();
        run_scan(-1, -1);
    endtask

    task automatic t_stalled_scans();
        run_scan(20, -1);
        run_scan(NN - 1, -1);
        run_scan(0, -1);
    endtask

    task automatic t_busy_start();
        run_scan(-1, 10);
        run_scan(-1, NN - 1);
    endtask

    task automatic t_mid_reset();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(valid_o == 1'b1, "R10", "busy before reset", int'(valid_o), 1);
        rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        chk(valid_o == 1'b0, "R10", "valid after reset", int'(valid_o), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(valid_o == 1'b0, "R10", "stays idle", int'(valid_o), 0);
        end
        run_scan(-1, -1);
    endtask

    initial begin
        build_expected();
        t_reset_state();
        t_plain_scan();
        t_stalled_scans();
        t_busy_start();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule